// File: doc/BRIEF.md
# DMA Width and Alignment Converter

This block sits between the read phase and the write phase of one DMA item. It receives the source and destination data sizes, the current source and destination addresses, and the 32-bit word returned by the read. It picks the source item out of the correct byte lanes of the read word and resizes it to the destination width. It then produces the write data, the byte-lane strobes for a 32-bit write bus, and both addresses forced to the alignment their sizes require.

A narrower source is zero-extended and a wider source keeps only its low-order bytes. For a byte or half-word write, the item is repeated across the whole 32-bit write bus. A slave that ignores the transfer size therefore still latches the right value. A reserved size code on either side raises a configuration error, and no lanes are enabled for that item.

All outputs are registered. Each result appears one clock after its inputs are presented. Address stepping, bus timing and error responses belong to the surrounding DMA channel.

Top module: `dma_width_adapter`

## Requirements
- R1: While `rst_n` is low, every output is zero.
- R2: Sizes are coded 2'b00 = 8-bit, 2'b01 = 16-bit, 2'b10 = 32-bit, and 2'b11 is reserved. Every output reflects the inputs sampled at the previous rising clock edge.
- R3: The source item is read from byte lanes of `rd_data`. The first lane is the source address offset (address bits 1:0, after alignment), and lane k is `rd_data[8k+7:8k]`.
- R4: When the destination is wider than the source, the bytes above the source item are zero. For example, an 8-bit 0xB0 written as 32 bits gives 0x000000B0.
- R5: When the destination is narrower than the source, only the least significant bytes of the source item are kept.
- R6: `src_addr_al` equals `src_addr` with bit 0 cleared for a 16-bit source and with bits 1:0 cleared for a 32-bit source. It is unchanged for an 8-bit source.
- R7: `dst_addr_al` follows the same alignment rule using the destination size.
- R8: `wr_strb` bit k enables lane k. An 8-bit write enables the single lane at the aligned destination offset. A 16-bit write enables two lanes starting at that offset. A 32-bit write enables all four lanes.
- R9: An 8-bit write places the byte on all four lanes of `wr_data`. A 16-bit write places the half-word on both halves of `wr_data`.
- R10: If either size is 2'b11, `cfg_err` is 1, and `wr_data`, `wr_strb`, `src_addr_al` and `dst_addr_al` are all zero. Otherwise `cfg_err` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_size | input | 2 | Source item size code |
| dst_size | input | 2 | Destination item size code |
| src_addr | input | ADDR_W | Current source address |
| dst_addr | input | ADDR_W | Current destination address |
| rd_data | input | 32 | Word returned by the source read |
| wr_data | output | 32 | Write data, replicated for narrow writes |
| wr_strb | output | 4 | Byte-lane enables for the write |
| src_addr_al | output | ADDR_W | Aligned source address |
| dst_addr_al | output | ADDR_W | Aligned destination address |
| cfg_err | output | 1 | Reserved size code seen |

## Verification
Every result of this block is due exactly one rising edge after its inputs. This holds for the data, the strobes, both aligned addresses and the error flag.

The bench drives a new vector on each falling edge and computes the expected outputs for that vector from the requirements alone. It compares them at the next falling edge, after the one register stage has captured the vector. As a result, every compare lines up with the vector that produced it. This stays true even when vectors arrive back to back in every cycle.

The stimulus covers the following cases:
- the worked 8-to-32 addressing sequence;
- each width pairing, including truncation and zero extension;
- misaligned addresses;
- reserved codes;
- a long run of random vectors.

// File: rtl/dma_width_adapter.sv
module dma_width_adapter #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        src_size,
  input  logic [1:0]        dst_size,
  input  logic [ADDR_W-1:0] src_addr,
  input  logic [ADDR_W-1:0] dst_addr,
  input  logic [31:0]       rd_data,
  output logic [31:0]       wr_data,
  output logic [3:0]        wr_strb,
  output logic [ADDR_W-1:0] src_addr_al,
  output logic [ADDR_W-1:0] dst_addr_al,
  output logic              cfg_err
);
  localparam logic [1:0] SZ_B = 2'b00;
  localparam logic [1:0] SZ_H = 2'b01;
  localparam logic [1:0] SZ_W = 2'b10;
  localparam logic [1:0] SZ_X = 2'b11;

  function automatic logic [1:0] low_mask(input logic [1:0] sz);
    case (sz)
      SZ_H:    return 2'b01;
      SZ_W:    return 2'b11;
      default: return 2'b00;
    endcase
  endfunction

  logic        bad;
  logic [1:0]  s_off, d_off;
  logic [31:0] shifted, item, wdata_n;
  logic [3:0]  strb_n;

  assign bad     = (src_size == SZ_X) || (dst_size == SZ_X);
  assign s_off   = src_addr[1:0] & ~low_mask(src_size);
  assign d_off   = dst_addr[1:0] & ~low_mask(dst_size);
  assign shifted = rd_data >> {s_off, 3'b000};

  always_comb begin
    case (src_size)
      SZ_B:    item = {24'h0, shifted[7:0]};
      SZ_H:    item = {16'h0, shifted[15:0]};
      default: item = shifted;
    endcase
  end

  always_comb begin
    case (dst_size)
      SZ_B: begin
        wdata_n = {4{item[7:0]}};
        strb_n  = 4'b0001 << d_off;
      end
      SZ_H: begin
        wdata_n = {2{item[15:0]}};
        strb_n  = 4'b0011 << d_off;
      end
      default: begin
        wdata_n = item;
        strb_n  = 4'hF;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n || bad) begin
      wr_data     <= '0;
      wr_strb     <= '0;
      src_addr_al <= '0;
      dst_addr_al <= '0;
      cfg_err     <= rst_n && bad;
    end else begin
      wr_data     <= wdata_n;
      wr_strb     <= strb_n;
      src_addr_al <= {src_addr[ADDR_W-1:2], s_off};
      dst_addr_al <= {dst_addr[ADDR_W-1:2], d_off};
      cfg_err     <= 1'b0;
    end
  end

  a_r10_err_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    bad |=> (cfg_err && wr_strb == 4'h0 && wr_data == 32'h0));
  a_r10_no_false_err: assert property (@(posedge clk) disable iff (!rst_n)
    !bad |=> !cfg_err);
  a_r8_byte_one_lane: assert property (@(posedge clk) disable iff (!rst_n)
    (!bad && dst_size == SZ_B) |=> $countones(wr_strb) == 1);
  a_r8_half_two_lanes: assert property (@(posedge clk) disable iff (!rst_n)
    (!bad && dst_size == SZ_H) |=> (wr_strb == 4'b0011 || wr_strb == 4'b1100));
  a_r8_word_all_lanes: assert property (@(posedge clk) disable iff (!rst_n)
    (!bad && dst_size == SZ_W) |=> wr_strb == 4'hF);
  a_r9_byte_repeat: assert property (@(posedge clk) disable iff (!rst_n)
    (!bad && dst_size == SZ_B) |=> (wr_data[31:16] == wr_data[15:0] && wr_data[15:8] == wr_data[7:0]));
  a_r9_half_repeat: assert property (@(posedge clk) disable iff (!rst_n)
    (!bad && dst_size == SZ_H) |=> wr_data[31:16] == wr_data[15:0]);
  a_r6_src_word_align: assert property (@(posedge clk) disable iff (!rst_n)
    (!bad && src_size == SZ_W) |=> src_addr_al[1:0] == 2'b00);
  a_r6_src_half_align: assert property (@(posedge clk) disable iff (!rst_n)
    (!bad && src_size == SZ_H) |=> !src_addr_al[0]);
  a_r7_dst_word_align: assert property (@(posedge clk) disable iff (!rst_n)
    (!bad && dst_size == SZ_W) |=> dst_addr_al[1:0] == 2'b00);
  a_r4_zero_extend: assert property (@(posedge clk) disable iff (!rst_n)
    (!bad && src_size == SZ_B && dst_size == SZ_W) |=> wr_data[31:8] == 24'h0);
endmodule

// File: tb/dma_width_adapter_tb_top.sv
`timescale 1ns/1ps
module dma_width_adapter_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  src_size = 2'b00, dst_size = 2'b00;
  logic [31:0] src_addr = '0, dst_addr = '0, rd_data = '0;
  logic [31:0] wr_data, src_addr_al, dst_addr_al;
  logic [3:0]  wr_strb;
  logic        cfg_err;

  int vectors = 0;
  int errors  = 0;
  bit done    = 1'b0;

  always #4 clk = ~clk;

  dma_width_adapter #(.ADDR_W(32)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .src_size(src_size), .dst_size(dst_size),
    .src_addr(src_addr), .dst_addr(dst_addr), .rd_data(rd_data),
    .wr_data(wr_data), .wr_strb(wr_strb),
    .src_addr_al(src_addr_al), .dst_addr_al(dst_addr_al), .cfg_err(cfg_err));

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic model(input logic [1:0] ss, input logic [1:0] ds,
                       input logic [31:0] sa, input logic [31:0] da, input logic [31:0] rd,
                       output logic [31:0] ed, output logic [3:0] es,
                       output logic [31:0] esa, output logic [31:0] eda, output logic ee);
    int sw, dw, so, dof;
    logic [7:0] itm [4];
    ed = '0; es = '0; esa = '0; eda = '0; ee = 1'b1;
    if (ss == 2'b11 || ds == 2'b11) return;
    ee = 1'b0;
    sw = 1 << ss; dw = 1 << ds;
    so = (int'(sa[1:0]) / sw) * sw;
    dof = (int'(da[1:0]) / dw) * dw;
    for (int j = 0; j < 4; j++) begin
      itm[j] = 8'h00;
      if (j < sw) itm[j] = rd[8*(so+j) +: 8];
    end
    for (int l = 0; l < 4; l++) begin
      ed[8*l +: 8] = itm[l % dw];
      es[l] = (l >= dof) && (l < dof + dw);
    end
    esa = sa - (sa % sw);
    eda = da - (da % dw);
  endtask

  task automatic apply(input logic [1:0] ss, input logic [1:0] ds,
                       input logic [31:0] sa, input logic [31:0] da, input logic [31:0] rd);
    logic [31:0] ed, esa, eda;
    logic [3:0]  es;
    logic        ee;
    src_size = ss; dst_size = ds; src_addr = sa; dst_addr = da; rd_data = rd;
    model(ss, ds, sa, da, rd, ed, es, esa, eda, ee);
    @(negedge clk);
    // R2: one register stage, compared one edge later
    check(wr_data == ed, "R2 R3 R4 R5 R9 wr_data", wr_data, ed);
    check(wr_strb == es, "R8 wr_strb", {28'h0, wr_strb}, {28'h0, es});
    check(src_addr_al == esa, "R6 src_addr_al", src_addr_al, esa);
    check(dst_addr_al == eda, "R7 dst_addr_al", dst_addr_al, eda);
    check(cfg_err == ee, "R10 cfg_err", {31'h0, cfg_err}, {31'h0, ee});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check(wr_data == 0 && wr_strb == 0 && !cfg_err && src_addr_al == 0 && dst_addr_al == 0,
          "R1 reset outputs", wr_data, 32'h0);
    rst_n = 1'b1;
    // R4: 8-to-32 worked sequence, src 0,1,2 dst 0,4,8
    apply(2'b00, 2'b10, 32'h0, 32'h0, 32'hB3B2B1B0);
    apply(2'b00, 2'b10, 32'h1, 32'h4, 32'hB3B2B1B0);
    apply(2'b00, 2'b10, 32'h2, 32'h8, 32'hB3B2B1B0);
    // R5: 32-to-8 and 32-to-16 truncation
    apply(2'b10, 2'b00, 32'h7, 32'h3, 32'hB7B6B5B4);
    apply(2'b10, 2'b01, 32'hB, 32'h6, 32'hBBBAB9B8);
    // R3: 16-bit source in upper half, misaligned address
    apply(2'b01, 2'b01, 32'h1003, 32'h2001, 32'hCAFE1234);
    apply(2'b01, 2'b10, 32'h2, 32'h5, 32'hB3B2B1B0);
    // R10: reserved codes on each side
    apply(2'b11, 2'b00, 32'h10, 32'h20, 32'hFFFFFFFF);
    apply(2'b00, 2'b11, 32'h10, 32'h20, 32'hFFFFFFFF);
    apply(2'b10, 2'b10, 32'h13, 32'h27, 32'h01234567);
    for (int n = 0; n < 3000; n++)
      apply(2'($urandom_range(0, 3)), 2'($urandom_range(0, 3)), $urandom, $urandom, $urandom);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      vectors++; errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end
endmodule